// File: doc/BRIEF.md
# External Bus Cycle Controller with Acknowledge Timeout

This block runs single asynchronous bus cycles toward one external chip-select region. An internal master presents an address, write data, a direction and byte enables together with a start request. The block drives the external address, an active-low chip select, an active-low output enable, a read/write level and four active-low byte strobes. It then waits for the cycle to finish.

A cycle ends in one of two ways. In wait-count mode, the cycle finishes after a programmed number of clocks, and the external acknowledge input has no effect. In acknowledge mode, the cycle finishes when a synchronized external acknowledge arrives. A fixed watchdog ends the cycle with a bus error if no acknowledge comes in time. Read data is captured on the terminating edge. The outcome is returned as a one-clock done or error pulse.

Two configuration bits change the strobes. One delays the output enable and the byte strobes by one clock after the cycle starts. The other keeps the byte strobes inactive during reads. Configuration is sampled when a cycle is accepted.

Top module: `ebc_ctrl`

## Requirements
- R1: A request is accepted only while `busy_o` is low. A request raised during a cycle does not change the external address or the length of that cycle.
- R2: `ext_rw_o` is high during a read cycle and low during a write cycle. `ext_cs_no` is low for exactly the clocks of the cycle.
- R3: `ext_oe_no` is active low and asserts only during read cycles.
- R4: Byte strobe `ext_eb_no[k]` gates data bits [31-8k : 24-8k]. Strobe 0 covers the most significant byte and strobe 3 the least significant byte. Request enable `req_be_i[j]` refers to data bits [8j+7 : 8j], so strobe k follows `req_be_i[3-k]`.
- R5: When `cfg_rd_no_eb_i` is 1, every byte strobe stays high throughout a read cycle. Writes are unaffected.
- R6: When `cfg_late_strobe_i` is 1, the output enable and the byte strobes stay inactive in the first clock of the cycle and assert from the second. When it is 0, they assert in the first clock.
- R7: When `cfg_use_wait_i` is 1, the cycle lasts `cfg_wait_i`+1 clocks with the chip select low, then ends with done. The acknowledge input is ignored in this mode.
- R8: In acknowledge mode, `ext_ack_ni` passes through a two-flop synchronizer. If it is first seen low during the clock with index d of the cycle (0-based), the cycle lasts d+3 clocks and ends with done.
- R9: In acknowledge mode with no acknowledge, the cycle lasts 1022 clocks and ends with `rsp_err_o` instead of done.
- R10: Done and error are single-clock pulses, never together. In the clock of the pulse, the chip select, the output enable and all strobes are negated and `busy_o` is low.
- R11: On a read, `rsp_rdata_o` holds the value of `ext_rdata_i` present in the last clock of the cycle.
- R12: After reset the block is idle, all active-low outputs are high, and done and error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start request |
| req_addr_i | input | AW | Cycle address |
| req_wdata_i | input | 32 | Write data |
| req_we_i | input | 1 | 1 write, 0 read |
| req_be_i | input | 4 | Byte enables, bit j for data [8j+7:8j] |
| cfg_use_wait_i | input | 1 | 1 end on wait count, 0 end on acknowledge |
| cfg_wait_i | input | WAIT_W | Wait count |
| cfg_late_strobe_i | input | 1 | Delay strobes by one clock |
| cfg_rd_no_eb_i | input | 1 | Suppress byte strobes on reads |
| busy_o | output | 1 | Cycle in progress |
| ext_addr_o | output | AW | External address |
| ext_cs_no | output | 1 | Chip select, active low |
| ext_oe_no | output | 1 | Output enable, active low |
| ext_rw_o | output | 1 | High read, low write |
| ext_eb_no | output | 4 | Byte strobes, active low |
| ext_wdata_o | output | 32 | External write data |
| ext_wdata_oe_o | output | 1 | Write data drive enable |
| ext_rdata_i | input | 32 | External read data |
| ext_ack_ni | input | 1 | External acknowledge, active low |
| rsp_done_o | output | 1 | Cycle completed pulse |
| rsp_err_o | output | 1 | Bus error pulse |
| rsp_rdata_o | output | 32 | Captured read data |

## Verification
The bench measures cycle length in clocks against the count predicted from the mode, the wait value and the acknowledge position.

It targets the following errors:
- An off-by-one in the wait compare or a missing synchronizer stage shifts that length by one.
- An acknowledge leaking into wait-count mode ends the cycle early.
- A watchdog one count short or long fails the 1022-clock error case.

Strobe checks in the first two clocks catch a reversed byte-lane order, a late-strobe option that does nothing, and strobes that fire on reads while suppressed. Read data is varied every clock, so capturing one edge early or late returns the wrong word. A stray request raised mid-cycle exposes a design that accepts work while busy.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int NBYTES = 4;
  localparam int DW     = 8 * NBYTES;

  typedef enum logic {
    ST_IDLE,
    ST_ACTIVE
  } ebc_state_e;
endpackage

// File: rtl/ebc_ack_sync.sv
module ebc_ack_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_ni,
  output logic ack_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= ack_ni;
      s2_q <= s1_q;
    end
  end

  assign ack_o = ~s2_q;
endmodule

// File: rtl/ebc_cycle_cnt.sv
module ebc_cycle_cnt #(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ebc_strobe.sv
module ebc_strobe #(
  parameter int NB = 4
) (
  input  logic          strobe_on_i,
  input  logic          rd_i,
  input  logic          rd_no_eb_i,
  input  logic [NB-1:0] be_i,
  output logic [NB-1:0] eb_no,
  output logic          oe_no
);
  logic eb_allow;
  assign eb_allow = strobe_on_i && (!rd_i || !rd_no_eb_i);

  // strobe k drives the lane counted from the top byte down
  for (genvar k = 0; k < NB; k++) begin : g_lane
    assign eb_no[k] = ~(eb_allow && be_i[NB-1-k]);
  end

  assign oe_no = ~(strobe_on_i && rd_i);
endmodule

// File: rtl/ebc_ctrl.sv
module ebc_ctrl
  import ebc_pkg::*;
#(
  parameter int AW      = 24,
  parameter int WAIT_W  = 6,
  parameter int TIMEOUT = 1022
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  input  logic              req_we_i,
  input  logic [NBYTES-1:0] req_be_i,
  input  logic              cfg_use_wait_i,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  input  logic              cfg_late_strobe_i,
  input  logic              cfg_rd_no_eb_i,
  output logic              busy_o,
  output logic [AW-1:0]     ext_addr_o,
  output logic              ext_cs_no,
  output logic              ext_oe_no,
  output logic              ext_rw_o,
  output logic [NBYTES-1:0] ext_eb_no,
  output logic [DW-1:0]     ext_wdata_o,
  output logic              ext_wdata_oe_o,
  input  logic [DW-1:0]     ext_rdata_i,
  input  logic              ext_ack_ni,
  output logic              rsp_done_o,
  output logic              rsp_err_o,
  output logic [DW-1:0]     rsp_rdata_o
);
  localparam int TW = $clog2(TIMEOUT);
  localparam int CW = (TW > WAIT_W) ? TW : WAIT_W;
  localparam logic [CW-1:0] TO_LAST = CW'(TIMEOUT - 1);

  ebc_state_e        state_q;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     wdata_q;
  logic              we_q, use_wait_q, late_q, rd_no_eb_q;
  logic [NBYTES-1:0] be_q;
  logic [WAIT_W-1:0] wait_q;
  logic              done_q, err_q;
  logic [DW-1:0]     rdata_q;
  logic [CW-1:0]     cnt;
  logic              ack_s;

  logic active, start, hit_wait, hit_ack, hit_to, term, strobe_on;

  assign active   = (state_q == ST_ACTIVE);
  assign start    = (state_q == ST_IDLE) && req_i;
  assign hit_wait = use_wait_q && (cnt == CW'(wait_q));
  assign hit_ack  = !use_wait_q && ack_s;
  assign hit_to   = !use_wait_q && !ack_s && (cnt == TO_LAST);
  assign term     = active && (hit_wait || hit_ack || hit_to);
  assign strobe_on = active && (!late_q || cnt != '0);

  ebc_ack_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ack_ni (ext_ack_ni),
    .ack_o  (ack_s)
  );

  ebc_cycle_cnt #(.CW(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start),
    .en_i   (active),
    .cnt_o  (cnt)
  );

  ebc_strobe #(.NB(NBYTES)) u_strb (
    .strobe_on_i (strobe_on),
    .rd_i        (!we_q),
    .rd_no_eb_i  (rd_no_eb_q),
    .be_i        (be_q),
    .eb_no       (ext_eb_no),
    .oe_no       (ext_oe_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      wdata_q    <= '0;
      we_q       <= 1'b0;
      be_q       <= '0;
      use_wait_q <= 1'b0;
      wait_q     <= '0;
      late_q     <= 1'b0;
      rd_no_eb_q <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      rdata_q    <= '0;
    end else begin
      done_q <= term && !hit_to;
      err_q  <= term && hit_to;
      if (start) begin
        state_q    <= ST_ACTIVE;
        addr_q     <= req_addr_i;
        wdata_q    <= req_wdata_i;
        we_q       <= req_we_i;
        be_q       <= req_be_i;
        use_wait_q <= cfg_use_wait_i;
        wait_q     <= cfg_wait_i;
        late_q     <= cfg_late_strobe_i;
        rd_no_eb_q <= cfg_rd_no_eb_i;
      end else if (term) begin
        state_q <= ST_IDLE;
        if (!we_q) rdata_q <= ext_rdata_i;
      end
    end
  end

  assign busy_o         = active;
  assign ext_addr_o     = addr_q;
  assign ext_cs_no      = ~active;
  assign ext_rw_o       = ~(active && we_q);
  assign ext_wdata_o    = wdata_q;
  assign ext_wdata_oe_o = active && we_q;
  assign rsp_done_o     = done_q;
  assign rsp_err_o      = err_q;
  assign rsp_rdata_o    = rdata_q;

  // R1
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_cs_no && $past(!ext_cs_no)) |-> $stable(ext_addr_o));

  // R3
  oe_read_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_oe_no |-> (ext_rw_o && !ext_cs_no));

  // R5
  rd_eb_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !we_q && rd_no_eb_q) |-> (&ext_eb_no));

  // R9
  err_ack_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (!rsp_done_o && !$past(use_wait_q)));

  // R10
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_done_o || rsp_err_o) |=> !(rsp_done_o || rsp_err_o));

  // R10
  idle_on_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_done_o || rsp_err_o) |-> (ext_cs_no && ext_oe_no && (&ext_eb_no) && !busy_o));
endmodule

// File: tb/tb_ebc_ctrl.sv
module tb_ebc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int WAIT_W = 6;
  localparam int TIMEOUT = 1022;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic req_we_i = 1'b0;
  logic [3:0] req_be_i = '0;
  logic cfg_use_wait_i = 1'b0;
  logic [WAIT_W-1:0] cfg_wait_i = '0;
  logic cfg_late_strobe_i = 1'b0;
  logic cfg_rd_no_eb_i = 1'b0;
  logic busy_o;
  logic [AW-1:0] ext_addr_o;
  logic ext_cs_no, ext_oe_no, ext_rw_o, ext_wdata_oe_o;
  logic [3:0] ext_eb_no;
  logic [31:0] ext_wdata_o;
  logic [31:0] ext_rdata_i = '0;
  logic ext_ack_ni = 1'b1;
  logic rsp_done_o, rsp_err_o;
  logic [31:0] rsp_rdata_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ebc_ctrl #(.AW(AW), .WAIT_W(WAIT_W), .TIMEOUT(TIMEOUT)) dut (.*);

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_eb(input logic on, input logic we,
                                        input logic nord, input logic [3:0] be);
    logic [3:0] r;
    for (int k = 0; k < 4; k++) r[k] = ~(on && be[3-k] && (we || !nord));
    return r;
  endfunction

  function automatic int exp_len(input logic use_wait, input int wt, input int ack_at);
    if (use_wait) return wt + 1;
    if (ack_at >= 0 && ack_at + 3 <= TIMEOUT) return ack_at + 3;
    return TIMEOUT;
  endfunction

  task automatic run_cycle(input logic we, input logic [3:0] be, input logic [AW-1:0] addr,
                           input logic [31:0] wd, input logic use_wait, input int wt,
                           input logic late, input logic nord, input int ack_at,
                           input logic poke);
    int n;
    int exp_n;
    logic [31:0] rbase;
    logic [31:0] last_rd;
    logic on;
    rbase = $urandom;
    last_rd = '0;
    @(negedge clk_i);
    req_i = 1'b1; req_addr_i = addr; req_wdata_i = wd; req_we_i = we; req_be_i = be;
    cfg_use_wait_i = use_wait; cfg_wait_i = WAIT_W'(wt);
    cfg_late_strobe_i = late; cfg_rd_no_eb_i = nord;
    @(negedge clk_i);
    req_i = 1'b0;
    req_addr_i = ~addr;
    n = 0;
    while (!(rsp_done_o || rsp_err_o) && n < 2000) begin
      chk(!ext_cs_no && busy_o, "R2 cs low in cycle", ext_cs_no, 0);
      if (n <= 1) begin
        on = !late || (n == 1);
        chk(ext_rw_o == !we, "R2 rw level", ext_rw_o, !we);
        chk(ext_eb_no == exp_eb(on, we, nord, be), "R4/R5/R6 byte strobes",
            ext_eb_no, exp_eb(on, we, nord, be));
        chk(ext_oe_no == !(on && !we), "R3/R6 output enable", ext_oe_no, !(on && !we));
        chk(ext_addr_o == addr, "R1 address", ext_addr_o, addr);
        if (we) chk(ext_wdata_o == wd && ext_wdata_oe_o, "R2 write data", ext_wdata_o, wd);
      end
      if (poke && n == 1) req_i = 1'b1;
      if (poke && n == 2) begin
        chk(ext_addr_o == addr, "R1 request ignored while busy", ext_addr_o, addr);
        req_i = 1'b0;
      end
      last_rd = rbase ^ 32'(n);
      ext_rdata_i = last_rd;
      if (n == ack_at) ext_ack_ni = 1'b0;
      n++;
      @(negedge clk_i);
    end
    req_i = 1'b0;
    exp_n = exp_len(use_wait, wt, ack_at);
    chk(n == exp_n, use_wait ? "R7 wait length" : (exp_n == TIMEOUT ? "R9 timeout length" : "R8 ack length"),
        n, exp_n);
    chk(rsp_err_o == (exp_n == TIMEOUT && !use_wait), "R9 error flag", rsp_err_o,
        (exp_n == TIMEOUT && !use_wait));
    chk(rsp_done_o != rsp_err_o, "R10 one response", rsp_done_o, !rsp_err_o);
    chk(ext_cs_no && ext_oe_no && ext_eb_no == 4'hF && !busy_o, "R10 idle on response",
        {ext_cs_no, ext_oe_no, ext_eb_no}, 6'h3F);
    if (!we) chk(rsp_rdata_o == last_rd, "R11 read capture", rsp_rdata_o, last_rd);
    ext_ack_ni = 1'b1;
    @(negedge clk_i);
    chk(!rsp_done_o && !rsp_err_o, "R10 single pulse", {rsp_done_o, rsp_err_o}, 0);
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk_i);
    // R12
    chk(ext_cs_no && ext_oe_no && ext_eb_no == 4'hF && !busy_o && !rsp_done_o && !rsp_err_o,
        "R12 reset state", {ext_cs_no, ext_oe_no, ext_eb_no, busy_o}, 7'h7E);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R4 lane order, write, single byte each
    for (int j = 0; j < 4; j++)
      run_cycle(1'b1, 4'(1 << j), 24'h100 + 24'(j), 32'hA5A5_0000 + 32'(j), 1'b1, 2, 1'b0, 1'b0, -1, 1'b0);
    // R5 read strobes suppressed, R6 late
    run_cycle(1'b0, 4'hF, 24'h200, 32'h0, 1'b1, 3, 1'b1, 1'b1, -1, 1'b0);
    run_cycle(1'b0, 4'hF, 24'h201, 32'h0, 1'b1, 3, 1'b1, 1'b0, -1, 1'b0);
    // R7 boundaries, ack ignored
    run_cycle(1'b0, 4'h3, 24'h300, 32'h0, 1'b1, 0, 1'b0, 1'b0, 0, 1'b0);
    run_cycle(1'b1, 4'hC, 24'h301, 32'h1234, 1'b1, 63, 1'b0, 1'b0, 1, 1'b0);
    // R8 earliest ack, R1 poke
    run_cycle(1'b0, 4'hF, 24'h400, 32'h0, 1'b0, 0, 1'b0, 1'b0, 0, 1'b0);
    run_cycle(1'b1, 4'hF, 24'h401, 32'hDEAD_BEEF, 1'b0, 0, 1'b1, 1'b0, 5, 1'b1);
    // R9 timeout
    run_cycle(1'b0, 4'hF, 24'h500, 32'h0, 1'b0, 0, 1'b0, 1'b0, -1, 1'b0);

    for (int t = 0; t < 40; t++) begin
      logic uw;
      uw = 1'($urandom);
      run_cycle(1'($urandom), 4'($urandom), AW'($urandom), $urandom, uw,
                int'($urandom % 16), 1'($urandom), 1'($urandom),
                int'($urandom % 12), 1'b0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule